// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Modem Flow Control

This block serialises characters onto one asynchronous line. Characters come in over a valid/ready write port into a single-entry holding register. When the shift stage is free, the character moves into it and goes out as a frame. The frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop period. All timing comes from a one-cycle enable, `tick16`, that pulses at sixteen times the bit rate. In 1x mode each pulse is instead one whole bit.

The stop period can be set in sixteenths of a bit through a 4-bit code, so a frame can be cut short or stretched to suit a slow receiver. Two flow-control features are optional. With clear-to-send gating on, a waiting character starts only while `cts` is high. With automatic ready-to-send release on, the `rts` output clears one bit time after the line fully drains, which ends a message without software timing.

Back-pressure rules on the write port:
- `wr_ready` is high exactly when the holding register is empty.
- A character is accepted on a cycle where `wr_valid` and `wr_ready` are both high.
- While `wr_ready` is low, the word on `wr_data` is neither taken nor allowed to disturb the stored character.
- The holding register frees up only on a `tick16` that starts a frame.

Top module: `async_tx`

## Requirements
- R1: After reset, `txd`=1, `wr_ready`=1, `thr_empty`=1, `tx_empty`=1 and `rts`=0. `tx_empty` is high when the holding register is empty and no frame is in progress, and `txd` is high whenever `tx_empty` is high.
- R2: Frame format. A bit lasts 16 `tick16` pulses. The frame is one low start bit, then the data bits least significant bit first, then the parity bit if `cfg_par_en`=1, then the high stop period. The number of data bits is `cfg_len`+5 (00→5, 11→8), and data bits above that count are ignored. With `cfg_par_odd`=0 the parity bit makes the count of ones across data and parity even; with `cfg_par_odd`=1 it makes that count odd. The first low tick appears on the `tick16` that starts the frame.
- R3: For 6, 7 and 8 data bits, stop code n on `cfg_stop` gives a stop period of 9+n ticks for n<8 and 17+n ticks for n≥8. This covers 9/16 to 1 bit and 1 9/16 to 2 bits.
- R4: For 5 data bits, stop code n gives a stop period of 17+n ticks, which is 1 1/16 to 2 bits.
- R5: Write handshake follows the back-pressure rules above. `thr_empty` equals `wr_ready`. A full holding register keeps its character until a frame starts.
- R6: If the holding register is full when a stop period ends (and gating allows), the next start bit follows on the very next tick with no idle gap.
- R7: With `cfg_cts_en`=1, a character starts only on a `tick16` while `cts`=1. Otherwise `txd` stays high and the character stays in the holding register.
- R8: With `cfg_cts_en`=1, `cts` falling during a frame does not alter that frame.
- R9: With `cfg_x1`=1, each `tick16` is one bit and the stop period is one bit (`cfg_two_stop`=0) or two bits (`cfg_two_stop`=1). `cfg_stop` is ignored in this mode.
- R10: `rts_set` sets `rts`. If `cfg_rts_auto`=1 and `cfg_cts_en`=0 when the last stop period ends, `rts` clears on the 16th `tick16` after the tick where `tx_empty` rises (the 1st in 1x mode). A write before then cancels the release.
- R11: With `cfg_rts_auto`=0, or with `cfg_cts_en`=1, the transmitter never clears `rts`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-cycle enable at 16x bit rate (bit rate in 1x mode) |
| wr_valid | input | 1 | Write strobe, character offered |
| wr_data | input | DW | Character to send, LSB goes first |
| wr_ready | output | 1 | Holding register can accept a character |
| cfg_len | input | 2 | Data bits minus five |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_stop | input | 4 | Stop-length code in sixteenths |
| cfg_x1 | input | 1 | 1x clock mode |
| cfg_two_stop | input | 1 | Two stop bits in 1x mode |
| cfg_cts_en | input | 1 | Gate each frame start on `cts` |
| cfg_rts_auto | input | 1 | Release `rts` after the line drains |
| cts | input | 1 | Clear-to-send, 1 = asserted |
| rts_set | input | 1 | Strobe that sets `rts` |
| txd | output | 1 | Serial line, idles high |
| rts | output | 1 | Ready-to-send output bit |
| thr_empty | output | 1 | Holding register empty |
| tx_empty | output | 1 | Holding register empty and no frame in progress |

## Verification
The bench builds the block with its default parameters: an 8-bit data port and 16 ticks per bit. With these values the 4-bit stop code spans its whole range, so the 9-, 16-, 17-, 25- and 32-tick stop periods can each be measured. The measurement places a second character right behind the first, so the length of each stop period shows up as the position of the next start bit. The same build also reaches the 1x path and the one-bit-time `rts` release through the configuration pins. Comparing the 16x and 1x releases exercises both values of the internal bit-length limit.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_PAR,
    TX_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_odd;
  } char_fmt_t;

endpackage

// File: rtl/async_tx_stopcalc.sv
// Maps the stop code and character length onto a stop period in ticks.
module async_tx_stopcalc #(
  parameter int OS     = 16,
  parameter int CODE_W = 4,
  parameter int CNT_W  = 6
) (
  input  logic [1:0]        len_code,
  input  logic [CODE_W-1:0] stop_code,
  input  logic              x1,
  input  logic              two_stop,
  output logic [CNT_W-1:0]  stop_ticks
);
  localparam int W2        = CNT_W + 2;
  localparam int HALF_BASE = OS / 2 + 1;
  localparam int FULL_BASE = OS + 1;
  localparam int CAP       = 2 * OS;
  localparam int HI        = CODE_W - 1;

  logic [W2-1:0] t;
  logic          long_range;

  // Short (sub-bit) range exists only for 6..8 data bits with code MSB clear.
  assign long_range = (len_code == 2'd0) || stop_code[HI];

  always_comb begin
    if (x1) begin
      t = two_stop ? W2'(2) : W2'(1);
    end else if (long_range) begin
      t = W2'(FULL_BASE) + W2'(stop_code);
    end else begin
      t = W2'(HALF_BASE) + W2'(stop_code);
    end
    if (t > W2'(CAP)) t = W2'(CAP);
    stop_ticks = CNT_W'(t);
  end
endmodule

// File: rtl/async_tx_hold.sv
// Single-entry holding register with a valid/ready write side.
module async_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          take,
  output logic          hold_full,
  output logic [DW-1:0] hold_data
);
  assign wr_ready = !hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else begin
      if (take) hold_full <= 1'b0;
      if (wr_valid && !hold_full) begin
        hold_full <= 1'b1;
        hold_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/async_tx_shift.sv
// Frame sequencer and shift register; drives the serial line.
module async_tx_shift
  import async_tx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int OS    = 16,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             x1,
  input  char_fmt_t        fmt,
  input  logic [CNT_W-1:0] stop_ticks,
  input  logic             cts_en,
  input  logic             cts,
  input  logic             hold_full,
  input  logic [DW-1:0]    hold_data,
  output logic             take,
  output logic             drain,
  output logic             busy,
  output logic             txd
);
  localparam int IDX_W = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OS - 1);

  tx_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] stop_q;
  logic [DW-1:0]    sh;
  logic [IDX_W-1:0] idx;
  logic [1:0]       len_q;
  logic             par_en_q;
  logic             par_q;

  logic [CNT_W-1:0] bit_last;
  logic [IDX_W-1:0] last_idx;
  logic             bit_end, stop_end, launch_ok, slot_free;

  function automatic logic calc_par(input logic [DW-1:0] d, input logic [1:0] len,
                                    input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < DW; i++) begin
      if (i < int'(len) + 5) p = p ^ d[i];
    end
    return p;
  endfunction

  assign bit_last  = x1 ? '0 : BIT_LAST;
  assign last_idx  = IDX_W'(len_q) + IDX_W'(4);
  assign bit_end   = (cnt == bit_last);
  assign stop_end  = (cnt == stop_q - CNT_W'(1));
  // Clear-to-send is looked at only at a frame boundary.
  assign launch_ok = hold_full && (!cts_en || cts);
  assign slot_free = (st == TX_IDLE) || (st == TX_STOP && stop_end);
  assign take      = tick && launch_ok && slot_free;
  assign drain     = tick && (st == TX_STOP) && stop_end && !launch_ok;
  assign busy      = (st != TX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= TX_IDLE;
      cnt      <= '0;
      stop_q   <= CNT_W'(1);
      sh       <= '0;
      idx      <= '0;
      len_q    <= '0;
      par_en_q <= 1'b0;
      par_q    <= 1'b0;
    end else if (take) begin
      st       <= TX_START;
      cnt      <= '0;
      sh       <= hold_data;
      idx      <= '0;
      len_q    <= fmt.len;
      par_en_q <= fmt.par_en;
      stop_q   <= stop_ticks;
      par_q    <= calc_par(hold_data, fmt.len, fmt.par_odd);
    end else if (tick) begin
      case (st)
        TX_IDLE: ;
        TX_START: begin
          if (bit_end) begin
            st  <= TX_DATA;
            cnt <= '0;
          end else cnt <= cnt + CNT_W'(1);
        end
        TX_DATA: begin
          if (bit_end) begin
            cnt <= '0;
            sh  <= sh >> 1;
            if (idx == last_idx) st <= par_en_q ? TX_PAR : TX_STOP;
            else idx <= idx + IDX_W'(1);
          end else cnt <= cnt + CNT_W'(1);
        end
        TX_PAR: begin
          if (bit_end) begin
            st  <= TX_STOP;
            cnt <= '0;
          end else cnt <= cnt + CNT_W'(1);
        end
        TX_STOP: begin
          if (stop_end) st <= TX_IDLE;
          else cnt <= cnt + CNT_W'(1);
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  always_comb begin
    txd = 1'b1;
    case (st)
      TX_START: txd = 1'b0;
      TX_DATA:  txd = sh[0];
      TX_PAR:   txd = par_q;
      default:  txd = 1'b1;
    endcase
  end
endmodule

// File: rtl/async_tx_rts.sv
// Ready-to-send bit: set by strobe, released one bit time after drain.
module async_tx_rts #(
  parameter int OS    = 16,
  parameter int CNT_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic x1,
  input  logic rts_set,
  input  logic auto_en,
  input  logic drain,
  input  logic tx_empty,
  output logic rts
);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OS - 1);

  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] bit_last;

  assign bit_last = x1 ? '0 : BIT_LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts   <= 1'b0;
      armed <= 1'b0;
      cnt   <= '0;
    end else begin
      if (drain) begin
        armed <= auto_en;
        cnt   <= '0;
      end else if (armed) begin
        if (!tx_empty) begin
          armed <= 1'b0;
        end else if (tick) begin
          if (cnt == bit_last) begin
            armed <= 1'b0;
            rts   <= 1'b0;
          end else cnt <= cnt + CNT_W'(1);
        end
      end
      if (rts_set) rts <= 1'b1;
    end
  end
endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
#(
  parameter int DW     = 8,
  parameter int OS     = 16,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              wr_valid,
  input  logic [DW-1:0]     wr_data,
  output logic              wr_ready,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic [CODE_W-1:0] cfg_stop,
  input  logic              cfg_x1,
  input  logic              cfg_two_stop,
  input  logic              cfg_cts_en,
  input  logic              cfg_rts_auto,
  input  logic              cts,
  input  logic              rts_set,
  output logic              txd,
  output logic              rts,
  output logic              thr_empty,
  output logic              tx_empty
);
  localparam int CNT_W = $clog2(2 * OS + 1);

  char_fmt_t        fmt;
  logic [CNT_W-1:0] stop_ticks;
  logic             hold_full, take, drain, sh_busy, auto_en;
  logic [DW-1:0]    hold_data;

  assign fmt       = '{len: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd};
  assign thr_empty = !hold_full;
  assign tx_empty  = !hold_full && !sh_busy;
  // Clear-to-send gating takes precedence over the automatic release.
  assign auto_en   = cfg_rts_auto && !cfg_cts_en;

  async_tx_stopcalc #(.OS(OS), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_stop (
    .len_code  (cfg_len),
    .stop_code (cfg_stop),
    .x1        (cfg_x1),
    .two_stop  (cfg_two_stop),
    .stop_ticks(stop_ticks)
  );

  async_tx_hold #(.DW(DW)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .wr_ready (wr_ready),
    .take     (take),
    .hold_full(hold_full),
    .hold_data(hold_data)
  );

  async_tx_shift #(.DW(DW), .OS(OS), .CNT_W(CNT_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick16),
    .x1        (cfg_x1),
    .fmt       (fmt),
    .stop_ticks(stop_ticks),
    .cts_en    (cfg_cts_en),
    .cts       (cts),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .take      (take),
    .drain     (drain),
    .busy      (sh_busy),
    .txd       (txd)
  );

  async_tx_rts #(.OS(OS), .CNT_W(CNT_W)) u_rts (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick16),
    .x1      (cfg_x1),
    .rts_set (rts_set),
    .auto_en (auto_en),
    .drain   (drain),
    .tx_empty(tx_empty),
    .rts     (rts)
  );
endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic wr_ready,
  input logic txd,
  input logic rts,
  input logic tx_empty,
  input logic busy,
  input logic cts,
  input logic cfg_cts_en,
  input logic cfg_rts_auto
);
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd);

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);

  a_r5_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && !tick16) |=> !wr_ready);

  a_r7_cts_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cts_en && !cts && !busy && tick16) |=> !busy);

  a_r10_rts_after_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts) |-> $past(tx_empty));

  a_r11_rts_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts) |-> $past(cfg_rts_auto && !cfg_cts_en));
endmodule

bind async_tx async_tx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick16      (tick16),
  .wr_ready    (wr_ready),
  .txd         (txd),
  .rts         (rts),
  .tx_empty    (tx_empty),
  .busy        (sh_busy),
  .cts         (cts),
  .cfg_cts_en  (cfg_cts_en),
  .cfg_rts_auto(cfg_rts_auto)
);

// File: tb/async_tx_test.sv
module async_tx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic [3:0] cfg_stop = 4'd7;
  logic       cfg_x1 = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic       cfg_cts_en = 1'b0;
  logic       cfg_rts_auto = 1'b0;
  logic       cts = 1'b1;
  logic       rts_set = 1'b0;
  logic       wr_ready, txd, rts, thr_empty, tx_empty;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  logic exp_w [0:2047];
  int   exp_len = 0;

  always #10 clk = ~clk;

  async_tx uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_stop(cfg_stop), .cfg_x1(cfg_x1),
    .cfg_two_stop(cfg_two_stop), .cfg_cts_en(cfg_cts_en), .cfg_rts_auto(cfg_rts_auto),
    .cts(cts), .rts_set(rts_set), .txd(txd), .rts(rts), .thr_empty(thr_empty),
    .tx_empty(tx_empty)
  );

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int bt();
    return cfg_x1 ? 1 : 16;
  endfunction

  function automatic int exp_stop();
    int nb = int'(cfg_len) + 5;
    if (cfg_x1) return cfg_two_stop ? 2 : 1;
    if (nb == 5 || cfg_stop >= 4'd8) return 17 + int'(cfg_stop);
    return 9 + int'(cfg_stop);
  endfunction

  task automatic push(logic lvl, int n);
    for (int i = 0; i < n; i++) begin
      exp_w[exp_len] = lvl;
      exp_len++;
    end
  endtask

  task automatic add_char(logic [7:0] d);
    int   nb = int'(cfg_len) + 5;
    logic p  = cfg_par_odd;
    push(1'b0, bt());
    for (int i = 0; i < nb; i++) begin
      push(d[i], bt());
      p = p ^ d[i];
    end
    if (cfg_par_en) push(p, bt());
    push(1'b1, exp_stop());
  endtask

  task automatic tick_once(output logic s);
    @(negedge clk) tick16 = 1'b1;
    @(negedge clk) tick16 = 1'b0;
    s = txd;
  endtask

  task automatic write_byte(logic [7:0] d);
    @(negedge clk);
    wr_data  = d;
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pulse_rts_set();
    @(negedge clk) rts_set = 1'b1;
    @(negedge clk) rts_set = 1'b0;
  endtask

  // Ticks through the expected waveform, comparing txd after every tick.
  task automatic run_wave(string req, bit do_wr, logic [7:0] wd, int drop_at);
    int   bad = 0;
    int   first = -1;
    logic s, fg, fe;
    fg = 1'b0;
    fe = 1'b0;
    for (int i = 0; i < exp_len; i++) begin
      tick_once(s);
      if (s !== exp_w[i]) begin
        if (bad == 0) begin
          first = i;
          fg = s;
          fe = exp_w[i];
        end
        bad++;
      end
      if (i == 0) begin
        if (do_wr) write_byte(wd);
        else if (wr_valid) begin
          @(negedge clk);
          wr_valid = 1'b0;
        end
      end
      if (i == drop_at) cts = 1'b0;
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s waveform at tick %0d: got %0b expected %0b (%0d bad)",
               req, first, fg, fe, bad);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "txd", txd, 1);
    chk("R1", "wr_ready", wr_ready, 1);
    chk("R1", "thr_empty", thr_empty, 1);
    chk("R1", "tx_empty", tx_empty, 1);
    chk("R1", "rts", rts, 0);
  endtask

  task automatic t_frame(string req, logic [1:0] len, logic pe, logic po, logic [3:0] code,
                         logic x1, logic two, logic [7:0] a, logic [7:0] b);
    cfg_len = len; cfg_par_en = pe; cfg_par_odd = po; cfg_stop = code;
    cfg_x1 = x1; cfg_two_stop = two; cfg_cts_en = 1'b0; cts = 1'b1;
    exp_len = 0;
    add_char(a);
    add_char(b);
    push(1'b1, 3 * bt());
    write_byte(a);
    run_wave(req, 1'b1, b, -1);
    chk(req, "tx_empty after frames", tx_empty, 1);
  endtask

  task automatic t_backpressure();
    cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_stop = 4'd7; cfg_x1 = 1'b0;
    cfg_cts_en = 1'b0; cts = 1'b1;
    exp_len = 0;
    add_char(8'h5A);
    add_char(8'h81);
    push(1'b1, 32);
    write_byte(8'h5A);
    chk("R5", "wr_ready while full", wr_ready, 0);
    chk("R5", "thr_empty while full", thr_empty, 0);
    @(negedge clk);
    wr_data = 8'hC3;
    wr_valid = 1'b1;
    repeat (5) @(negedge clk);
    chk("R5", "wr_ready stalled", wr_ready, 0);
    wr_data = 8'h81;
    run_wave("R5 R6 stalled word ignored", 1'b0, 8'h00, -1);
  endtask

  task automatic t_cts();
    int hi_miss = 0;
    logic s;
    cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_stop = 4'd7; cfg_x1 = 1'b0;
    cfg_cts_en = 1'b1; cts = 1'b0;
    write_byte(8'h96);
    for (int i = 0; i < 40; i++) begin
      tick_once(s);
      if (s !== 1'b1) hi_miss++;
    end
    chk("R7", "low ticks while cts negated", hi_miss, 0);
    chk("R7", "thr_empty while held", thr_empty, 0);
    cts = 1'b1;
    exp_len = 0;
    add_char(8'h96);
    push(1'b1, 60);
    run_wave("R8 cts drop mid-frame", 1'b1, 8'h4B, 40);
    chk("R7", "second char held", thr_empty, 0);
    chk("R7", "line idle while held", txd, 1);
    cts = 1'b1;
    exp_len = 0;
    add_char(8'h4B);
    push(1'b1, 20);
    run_wave("R7 release", 1'b0, 8'h00, -1);
    cfg_cts_en = 1'b0;
  endtask

  task automatic t_rts(string req, logic x1, logic auto_on, logic ctsen, bit expect_clear);
    int   k = -1;
    int   r = -1;
    logic s;
    cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_stop = 4'd7; cfg_x1 = x1;
    cfg_two_stop = 1'b0; cfg_cts_en = ctsen; cfg_rts_auto = auto_on; cts = 1'b1;
    pulse_rts_set();
    chk(req, "rts after set", rts, 1);
    write_byte(8'h3E);
    for (int i = 0; i < 600; i++) begin
      tick_once(s);
      if (k < 0 && tx_empty) k = i;
      if (r < 0 && !rts) r = i;
      if (k >= 0 && i > k + 40) break;
    end
    chk(req, "drain seen", (k >= 0) ? 1 : 0, 1);
    if (expect_clear) begin
      chk(req, "release delay in ticks", r - k, bt());
    end else begin
      chk(req, "rts kept", r, -1);
    end
    cfg_rts_auto = 1'b0;
    cfg_cts_en = 1'b0;
    cfg_x1 = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_frame("R2 R6 8N", 2'd3, 1'b0, 1'b0, 4'd7, 1'b0, 1'b0, 8'hA5, 8'h3C);
    t_frame("R2 R3 7E short stop", 2'd2, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 8'h53, 8'h7F);
    t_frame("R2 R3 6O code8", 2'd1, 1'b1, 1'b1, 4'd8, 1'b0, 1'b0, 8'h2A, 8'h15);
    t_frame("R3 8O code15", 2'd3, 1'b1, 1'b1, 4'd15, 1'b0, 1'b0, 8'hFF, 8'h00);
    t_frame("R4 5N code0", 2'd0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 8'hE6, 8'h05);
    t_frame("R4 5E code15", 2'd0, 1'b1, 1'b0, 4'd15, 1'b0, 1'b0, 8'h1B, 8'h0E);
    t_frame("R9 x1 one stop", 2'd3, 1'b0, 1'b0, 4'd3, 1'b1, 1'b0, 8'hC9, 8'h36);
    t_frame("R9 x1 two stop", 2'd2, 1'b1, 1'b1, 4'd3, 1'b1, 1'b1, 8'h71, 8'h0F);
    t_backpressure();
    t_cts();
    t_rts("R10 16x", 1'b0, 1'b1, 1'b0, 1'b1);
    t_rts("R10 x1", 1'b1, 1'b1, 1'b0, 1'b1);
    t_rts("R11 cts wins", 1'b0, 1'b1, 1'b1, 1'b0);
    t_rts("R11 auto off", 1'b0, 1'b0, 1'b0, 1'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule